// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block owns the program counter of a pipelined processor that uses byte addressing and fixed four-byte instructions. Each cycle it offers the fetch stage the current PC and the sequential address PC+4. That sequential value travels down the pipe as the incremented PC of the fetched instruction.

When an instruction reaches the execute stage, the unit does two things. It forms a PC-relative target: the incremented PC plus the sign-extended 16-bit immediate scaled by four. It also tests whether the first source operand is zero. The taken decision and the target are captured in the execute/memory pipeline register. On the next cycle the PC loads the target if that register holds a taken branch, and PC+4 if it does not.

Nothing is squashed. Instructions fetched behind a branch keep executing, and the compiler fills those delay slots. A stall input freezes the PC and the captured branch pair.

The captured pair is held by a two-state machine:
- `ST_SEQ`: no taken branch is pending.
- `ST_REDIR`: a taken branch is pending.

Its transitions are:
- `T_HOLD`: stall asserted, so the state is kept.
- `T_ARM`: no stall, and the execute-stage instruction is a branch whose operand is zero, giving `ST_REDIR`.
- `T_CLEAR`: no stall and no taken branch in execute, giving `ST_SEQ`.

Top module: `brnpc_unit`

## Requirements
- R1: While reset (active-low, asynchronous) is applied, `pc` is 0, `exm_taken` is 0 and `exm_target` is 0.
- R2: `pc_seq` always equals `pc + 4` (modulo 2^32).
- R3: On a clock edge without stall, `exm_target` takes `ex_npc + (sign_extend(ex_imm) << 2)`, with its two low bits forced to zero.
- R4: On a clock edge without stall, `exm_taken` becomes 1 exactly when `ex_branch` is 1 and `ex_opa` equals zero.
- R5: On a clock edge without stall, `pc` loads `exm_target` if `exm_taken` is 1, otherwise `pc + 4`. `next_pc` shows, before the edge, the value `pc` will load.
- R6: On a clock edge with `stall` at 1, `pc`, `exm_taken` and `exm_target` keep their values, and `next_pc` equals `pc`.
- R7: A branch presented in execute has no effect on the PC update of the same edge. That edge still advances `pc` by 4, so the delay-slot instructions are fetched; the redirect happens on the following unstalled edge.
- R8: The two low bits of `pc` are always zero.
- R9: A non-branch instruction (`ex_branch` = 0) whose `ex_opa` is zero never sets `exm_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes the PC and the captured branch pair |
| ex_branch | input | 1 | Instruction in execute is a conditional branch |
| ex_npc | input | 32 | Incremented PC of the instruction in execute |
| ex_imm | input | 16 | Raw immediate of the instruction in execute |
| ex_opa | input | 32 | First source operand of the instruction in execute |
| pc | output | 32 | Current program counter |
| pc_seq | output | 32 | Sequential address, pc + 4 |
| next_pc | output | 32 | Value pc loads on the next edge |
| exm_taken | output | 1 | Captured branch-taken flag |
| exm_target | output | 32 | Captured branch target |

## Verification
The in-RTL assertions check, on every cycle, the following relations:
- the stall freeze of the PC and of the captured pair;
- the choice of PC source from the captured flag;
- the taken flag as a function of the previous cycle's branch flag and operand;
- the word alignment of the PC.

The arithmetic of the target needs the bench's cycle-by-cycle reference model, in particular the sign extension of negative and extreme immediates and wrap-around. The same holds for the two-edge delay before a redirect, for back-to-back branches, and for a redirect held across a stall.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;
    typedef enum logic [0:0] {
        ST_SEQ   = 1'b0,
        ST_REDIR = 1'b1
    } redir_state_e;
endpackage

// File: rtl/brnpc_target.sv
module brnpc_target #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0] npc,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;

    always_comb begin
        imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        offset  = imm_ext << SHIFT;
        sum     = npc + offset;
        target  = {sum[XLEN-1:SHIFT], {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/brnpc_zero.sv
module brnpc_zero #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic            is_branch,
    output logic            take
);
    always_comb begin
        take = is_branch && (opa == '0);
    end
endmodule

// File: rtl/brnpc_exmem.sv
module brnpc_exmem
    import brnpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            take_in,
    input  logic [XLEN-1:0] target_in,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    redir_state_e state_q, state_d;
    logic [XLEN-1:0] target_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:   if (!stall && take_in)  state_d = ST_REDIR;
            ST_REDIR: if (!stall && !take_in) state_d = ST_SEQ;
            default:  state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SEQ;
            target_q <= '0;
        end else if (!stall) begin
            state_q  <= state_d;
            target_q <= target_in;
        end
    end

    always_comb begin
        taken  = (state_q == ST_REDIR);
        target = target_q;
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(taken) && $stable(target)));

    // R4
    taken_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (taken == $past(take_in)));
endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int INSTR_BYTES = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            ex_branch,
    input  logic [XLEN-1:0] ex_npc,
    input  logic [IMMW-1:0] ex_imm,
    input  logic [XLEN-1:0] ex_opa,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_seq,
    output logic [XLEN-1:0] next_pc,
    output logic            exm_taken,
    output logic [XLEN-1:0] exm_target
);
    localparam int SHIFT = $clog2(INSTR_BYTES);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] ex_target;
    logic            ex_take;

    brnpc_target #(.XLEN(XLEN), .IMMW(IMMW), .SHIFT(SHIFT)) u_target (
        .npc    (ex_npc),
        .imm    (ex_imm),
        .target (ex_target)
    );

    brnpc_zero #(.XLEN(XLEN)) u_zero (
        .opa       (ex_opa),
        .is_branch (ex_branch),
        .take      (ex_take)
    );

    brnpc_exmem #(.XLEN(XLEN)) u_exmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .take_in   (ex_take),
        .target_in (ex_target),
        .taken     (exm_taken),
        .target    (exm_target)
    );

    always_comb begin
        pc_seq = pc_q + STEP;
        if (stall)          next_pc = pc_q;
        else if (exm_taken) next_pc = exm_target;
        else                next_pc = pc_seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end

    assign pc = pc_q;

    // R6
    pc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    // R5
    pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && exm_taken) |=> (pc == $past(exm_target)));

    // R7
    pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !exm_taken) |=> (pc == $past(pc) + STEP));

    // R8
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[SHIFT-1:0] == '0);
endmodule

// File: tb/brnpc_unit_tb.sv
module brnpc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        ex_branch = 1'b0;
    logic [31:0] ex_npc = '0;
    logic [15:0] ex_imm = '0;
    logic [31:0] ex_opa = '0;
    logic [31:0] pc, pc_seq, next_pc, exm_target;
    logic        exm_taken;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] m_pc = '0;
    logic [31:0] m_target = '0;
    bit          m_taken = 0;

    always #4 clk = ~clk;

    brnpc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .ex_branch(ex_branch),
        .ex_npc(ex_npc), .ex_imm(ex_imm), .ex_opa(ex_opa), .pc(pc),
        .pc_seq(pc_seq), .next_pc(next_pc), .exm_taken(exm_taken),
        .exm_target(exm_target)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic step(input bit st, input bit br, input logic [31:0] npc,
                        input logic [15:0] imm, input logic [31:0] opa);
        logic [31:0] e_next, t;
        bit e_take;
        string tg;
        stall = st; ex_branch = br; ex_npc = npc; ex_imm = imm; ex_opa = opa;
        #1;
        e_next = st ? m_pc : (m_taken ? m_target : m_pc + 32'd4);
        check32(st ? "R6 next_pc" : "R5 next_pc", next_pc, e_next);
        e_take = br && (opa == 0);
        t = npc + ({{16{imm[15]}}, imm} << 2);
        t[1:0] = 2'b00;
        @(posedge clk);
        if (!st) begin
            m_pc = e_next; m_taken = e_take; m_target = t;
        end
        @(negedge clk);
        tg = st ? "R6 pc" : (br ? "R7 pc" : "R5 pc");
        check32(tg, pc, m_pc);
        check32("R2 pc_seq", pc_seq, m_pc + 32'd4);
        tg = st ? "R6 taken" : ((!br && opa == 0) ? "R9 taken" : "R4 taken");
        check32(tg, {31'd0, exm_taken}, {31'd0, m_taken});
        check32(st ? "R6 target" : "R3 target", exm_target, m_target);
        check32("R8 pc align", {30'd0, pc[1:0]}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check32("R1 pc", pc, 32'd0);
        check32("R1 taken", {31'd0, exm_taken}, 32'd0);
        check32("R1 target", exm_target, 32'd0);
        rst_n = 1'b1;
        // plain sequential run
        for (int i = 0; i < 4; i++) step(0, 0, 32'h100, 16'h0001, 32'h5);
        // taken branch with negative offset, then delay slot
        step(0, 1, 32'h0000_0010, 16'hFFFC, 32'h0);
        step(0, 0, 32'h0, 16'h0, 32'h1);
        step(0, 0, 32'h0, 16'h0, 32'h1);
        // not-taken branch (operand nonzero)
        step(0, 1, 32'h0000_2000, 16'h0040, 32'h1);
        step(0, 0, 32'h0, 16'h0, 32'h0);
        // non-branch with zero operand
        step(0, 0, 32'h0000_3000, 16'h0010, 32'h0);
        // extreme immediates
        step(0, 1, 32'h0001_0000, 16'h7FFF, 32'h0);
        step(0, 1, 32'h0001_0000, 16'h8000, 32'h0);
        step(0, 0, 32'h0, 16'h0, 32'h7);
        // redirect held across stall
        step(0, 1, 32'h0000_4000, 16'h0100, 32'h0);
        step(1, 0, 32'h0, 16'h0, 32'h3);
        step(1, 1, 32'h0000_9000, 16'h0001, 32'h9);
        step(0, 0, 32'h0, 16'h0, 32'h3);
        // wrap-around
        step(0, 1, 32'hFFFF_FFFC, 16'h0002, 32'h0);
        step(0, 0, 32'h0, 16'h0, 32'h1);
        step(0, 0, 32'h0, 16'h0, 32'h1);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rn;
            rn = $urandom;
            step(rn[3:0] == 4'd0, rn[4], $urandom & 32'hFFFF_FFFC, 16'($urandom),
                 rn[6:5] == 2'b00 ? 32'h0 : $urandom);
        end
        summary();
    end
endmodule